// File: doc/BRIEF.md
# Four-Phase Cycle and Memory Interface Controller

This block divides every datapath cycle into four ordered sub-cycle phases and announces them on a one-hot strobe output. The rest of the machine uses these strobes to sequence its own loads. The block also holds the two registers that sit between the processor and a slower memory. The address register drives a unidirectional address output. The buffer register drives a bidirectional data bus during writes, and it always feeds its value back to the datapath.

The phases run in a fixed order. Phase 1 loads the microinstruction. Phase 2 latches the operand buses. At the end of phase 3 the address register may capture the latched B value. At the end of phase 4 the buffer register may capture either the C bus or the memory data bus, and the scratchpad is written in the same phase.

Memory is slower than the datapath. A read or a write finishes only once its request line has been held high for `MEM_CYCLES` consecutive microinstructions. The default is two.

Top module: `memCycleCtrl`

## Requirements
- R1: `phaseStrobe` always has exactly one bit set. After reset, bit 0 (phase 1) is set, and on each clock the set bit moves up by one position, wrapping from bit 3 (phase 4) back to bit 0.
- R2: While the synchronous reset `rst` is high at a clock edge, the phase returns to phase 1, and `addrOut` and `mbrOut` are cleared to zero.
- R3: `addrOut` takes the value of `bLatch` (its low `ADDR_W` bits) only at the clock edge that ends phase 3 of a cycle in which `marLoad` is high. At all other times it keeps its value.
- R4: At the edge that ends phase 4, if `mbrLoad` is high and `memRd` is low, `mbrOut` takes the value of `cBus`. If `memRd` is high, `cBus` is ignored.
- R5: `mbrOut` changes only at the clock edge that ends phase 4.
- R6: When `memRd` has been high for `MEM_CYCLES` consecutive datapath cycles, `mbrOut` captures `dataBus` at the end of phase 4 of the last of those cycles. `accessDone` is high during that phase 4.
- R7: A run of `memRd` or `memWr` that is shorter than `MEM_CYCLES` and is then broken by an idle cycle completes nothing. `accessDone` stays low, `mbrOut` is unchanged, and the cycle count starts over.
- R8: `dataBus` is driven with `mbrOut` while `memWr` is high and `memRd` is low. Otherwise the block leaves it at high impedance.
- R9: When `memWr` has been high for `MEM_CYCLES` consecutive cycles, `accessDone` is high during phase 4 of the last of those cycles. `accessDone` is never high outside phase 4.
- R10: Runs of requests that follow one another without a gap complete once every `MEM_CYCLES` cycles. For example, four consecutive read cycles with `MEM_CYCLES`=2 give two completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-cycle clock, one edge per phase |
| rst | input | 1 | Synchronous reset, active high |
| marLoad | input | 1 | Capture bLatch into the address register in phase 3 |
| mbrLoad | input | 1 | Capture cBus into the buffer register in phase 4 |
| memRd | input | 1 | Read request for the current microinstruction |
| memWr | input | 1 | Write request for the current microinstruction |
| bLatch | input | DATA_W | Latched B operand bus value |
| cBus | input | DATA_W | Shifter result bus |
| addrOut | output | ADDR_W | Memory address, unidirectional |
| dataBus | inout | DATA_W | Memory data bus |
| mbrOut | output | DATA_W | Buffer register value, fed to the ALU input mux |
| phaseStrobe | output | 4 | One-hot phase indicator, bit 0 = phase 1 |
| accessDone | output | 1 | High in phase 4 of the cycle that completes a memory access |

## Verification
The bench builds the block with `DATA_W` and `ADDR_W` set to 8 and `MEM_CYCLES` set to 2. With these values a bench-side memory of 256 bytes can cover every address. Every byte value is swept through the address register and through the C-bus path, and every address is read back through the memory path against contents computed arithmetically. A spread of addresses is written and then read again through the block, which exercises the bus drive and the completion strobe. Short runs, runs broken by gaps, back-to-back runs and a reset in the middle of operation cover the corner cases of the access count.

// File: rtl/memcyc_pkg.sv
package memcyc_pkg;

  // Load and drive strobes issued by the phase controller to the datapath
  typedef struct packed {
    logic marLatch;    // address register captures the B latch
    logic mbrFromC;    // buffer register captures the C bus
    logic mbrFromMem;  // buffer register captures the memory bus
    logic busDrive;    // buffer register drives the memory bus
  } strobes_t;

  localparam int unsigned PHASE_COUNT = 4;
  localparam int unsigned PHASE_W     = 2;

  // Phase indices (phase 1 is index 0)
  localparam logic [PHASE_W-1:0] PH_FETCH   = 2'd0;
  localparam logic [PHASE_W-1:0] PH_LATCH   = 2'd1;
  localparam logic [PHASE_W-1:0] PH_ADDRESS = 2'd2;
  localparam logic [PHASE_W-1:0] PH_WRITE   = 2'd3;

endpackage

// File: rtl/memcyc_ctrl.sv
module memcyc_ctrl
  import memcyc_pkg::*;
#(
  parameter int unsigned MEM_CYCLES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   marLoad,
  input  logic                   mbrLoad,
  input  logic                   memRd,
  input  logic                   memWr,
  output logic [PHASE_COUNT-1:0] phaseStrobe,
  output logic                   accessDone,
  output strobes_t               strobes
);

  localparam int unsigned CNT_W = (MEM_CYCLES > 2) ? $clog2(MEM_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MEM_CYCLES - 1);

  logic [PHASE_W-1:0] phase;
  logic [CNT_W-1:0]   cycleCnt;
  logic               reqActive;
  logic               readReq;
  logic               writeReq;
  logic               inLastPhase;
  logic               lastCycle;

  // Free-running phase counter
  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= phase + PHASE_W'(1);
  end

  // One-hot phase strobes
  for (genvar g = 0; g < PHASE_COUNT; g++) begin : g_strobe
    assign phaseStrobe[g] = (phase == PHASE_W'(g));
  end

  assign readReq     = memRd;
  assign writeReq    = memWr && !memRd;
  assign reqActive   = memRd || memWr;
  assign inLastPhase = (phase == PH_WRITE);
  assign lastCycle   = (cycleCnt == LAST_CNT);

  // Count consecutive microinstructions that hold a memory request
  always_ff @(posedge clk) begin
    if (rst) begin
      cycleCnt <= '0;
    end else if (inLastPhase) begin
      if (!reqActive || lastCycle) cycleCnt <= '0;
      else                         cycleCnt <= cycleCnt + CNT_W'(1);
    end
  end

  assign accessDone = inLastPhase && reqActive && lastCycle;

  always_comb begin
    strobes            = '0;
    strobes.marLatch   = marLoad && (phase == PH_ADDRESS);
    strobes.mbrFromMem = inLastPhase && readReq && lastCycle;
    strobes.mbrFromC   = inLastPhase && mbrLoad && !readReq;
    strobes.busDrive   = writeReq;
  end

endmodule

// File: rtl/memcyc_dp.sv
module memcyc_dp
  import memcyc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] bLatch,
  input  logic [DATA_W-1:0] cBus,
  input  logic [DATA_W-1:0] busIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] mbrOut,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe
);

  logic [ADDR_W-1:0] marQ;
  logic [DATA_W-1:0] mbrQ;
  logic [DATA_W-1:0] mbrNext;

  // Address register: captured from the B latch
  always_ff @(posedge clk) begin
    if (rst)                   marQ <= '0;
    else if (strobes.marLatch) marQ <= bLatch[ADDR_W-1:0];
  end

  // Buffer register source select; memory data has priority
  always_comb begin
    mbrNext = mbrQ;
    if (strobes.mbrFromMem)    mbrNext = busIn;
    else if (strobes.mbrFromC) mbrNext = cBus;
  end

  always_ff @(posedge clk) begin
    if (rst) mbrQ <= '0;
    else     mbrQ <= mbrNext;
  end

  assign addrOut = marQ;
  assign mbrOut  = mbrQ;
  assign busOut  = mbrQ;
  assign busOe   = strobes.busDrive;

endmodule

// File: rtl/memCycleCtrl.sv
module memCycleCtrl
  import memcyc_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned MEM_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              marLoad,
  input  logic              mbrLoad,
  input  logic              memRd,
  input  logic              memWr,
  input  logic [DATA_W-1:0] bLatch,
  input  logic [DATA_W-1:0] cBus,
  output logic [ADDR_W-1:0] addrOut,
  inout  wire  [DATA_W-1:0] dataBus,
  output logic [DATA_W-1:0] mbrOut,
  output logic [3:0]        phaseStrobe,
  output logic              accessDone
);

  strobes_t          strobes;
  logic [DATA_W-1:0] busOut;
  logic              busOe;

  memcyc_ctrl #(
    .MEM_CYCLES(MEM_CYCLES)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .marLoad    (marLoad),
    .mbrLoad    (mbrLoad),
    .memRd      (memRd),
    .memWr      (memWr),
    .phaseStrobe(phaseStrobe),
    .accessDone (accessDone),
    .strobes    (strobes)
  );

  memcyc_dp #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .bLatch (bLatch),
    .cBus   (cBus),
    .busIn  (dataBus),
    .addrOut(addrOut),
    .mbrOut (mbrOut),
    .busOut (busOut),
    .busOe  (busOe)
  );

  assign dataBus = busOe ? busOut : {DATA_W{1'bz}};

endmodule

// File: rtl/memcyc_chk.sv
module memcyc_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              marLoad,
  input logic              memRd,
  input logic              memWr,
  input logic [ADDR_W-1:0] addrOut,
  input logic [DATA_W-1:0] mbrOut,
  input logic [DATA_W-1:0] dataBus,
  input logic [3:0]        phaseStrobe,
  input logic              accessDone
);

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(phaseStrobe) == 1); // R1

  AST_PHASE_ROTATE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phaseStrobe == {$past(phaseStrobe[2:0]), $past(phaseStrobe[3])}); // R1

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phaseStrobe == 4'b0001 && addrOut == '0 && mbrOut == '0)); // R2

  AST_MAR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(phaseStrobe[2] && marLoad) |=> $stable(addrOut)); // R3

  AST_MBR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !phaseStrobe[3] |=> $stable(mbrOut)); // R5

  AST_DONE_IN_LAST: assert property (@(posedge clk) disable iff (rst)
    accessDone |-> phaseStrobe[3]); // R9

  AST_BUS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (memWr && !memRd) |-> dataBus == mbrOut); // R8

endmodule

bind memCycleCtrl memcyc_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .marLoad    (marLoad),
  .memRd      (memRd),
  .memWr      (memWr),
  .addrOut    (addrOut),
  .mbrOut     (mbrOut),
  .dataBus    (dataBus),
  .phaseStrobe(phaseStrobe),
  .accessDone (accessDone)
);

// File: tb/memCycleCtrl_tb.sv
`timescale 1ns/1ps
module memCycleCtrl_tb_top;

  localparam int DW = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          marLoad, mbrLoad, memRd, memWr;
  logic [DW-1:0] bLatch, cBus;
  logic [AW-1:0] addrOut;
  wire  [DW-1:0] dataBus;
  logic [DW-1:0] mbrOut;
  logic [3:0]    phaseStrobe;
  logic          accessDone;

  logic [DW-1:0] tbMem [256];
  int            testCnt = 0;
  int            failCnt = 0;
  int            doneCnt = 0;
  bit            finished = 0;

  always #5 clk = ~clk;

  memCycleCtrl #(.DATA_W(DW), .ADDR_W(AW), .MEM_CYCLES(2)) dut_i (
    .clk(clk), .rst(rst), .marLoad(marLoad), .mbrLoad(mbrLoad),
    .memRd(memRd), .memWr(memWr), .bLatch(bLatch), .cBus(cBus),
    .addrOut(addrOut), .dataBus(dataBus), .mbrOut(mbrOut),
    .phaseStrobe(phaseStrobe), .accessDone(accessDone)
  );

  // Memory model: drives the bus while a read is requested
  assign dataBus = memRd ? tbMem[addrOut] : {DW{1'bz}};

  always @(posedge clk) begin
    if (!rst && accessDone) begin
      doneCnt <= doneCnt + 1;
      if (memWr && !memRd) tbMem[addrOut] <= dataBus;
    end
  end

  function automatic logic [DW-1:0] initVal(input int a);
    return DW'((a * 37 + 11) ^ 8'h5A);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One datapath cycle, entered and left at the falling edge in phase 1
  task automatic dpCycle(input logic mar, input logic mbr, input logic rd,
                         input logic wr, input logic [DW-1:0] b,
                         input logic [DW-1:0] c);
    marLoad = mar; mbrLoad = mbr; memRd = rd; memWr = wr;
    bLatch = b; cBus = c;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    dpCycle(0, 0, 0, 0, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int d0;
    logic [DW-1:0] holdMbr;
    for (int i = 0; i < 256; i++) tbMem[i] = initVal(i);
    rst = 1; marLoad = 0; mbrLoad = 0; memRd = 0; memWr = 0;
    bLatch = '0; cBus = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R2: reset state
    check(phaseStrobe == 4'b0001, "R2 phase", phaseStrobe, 1);
    check(addrOut == 0 && mbrOut == 0, "R2 regs", {addrOut, mbrOut}, 0);

    // R1: phase rotation over two datapath cycles
    for (int i = 0; i < 8; i++) begin
      check(phaseStrobe == 4'(1 << (i % 4)), "R1 rotate", phaseStrobe, 1 << (i % 4));
      @(negedge clk);
    end

    // R3: address register sweep, and hold when not loaded
    for (int v = 0; v < 256; v++) begin
      dpCycle(1, 0, 0, 0, DW'(v), 8'h00);
      check(addrOut == AW'(v), "R3 load", addrOut, v);
      if (v % 16 == 0) begin
        dpCycle(0, 0, 0, 0, DW'(~v), 8'h00);
        check(addrOut == AW'(v), "R3 hold", addrOut, v);
      end
    end

    // R4: buffer register from C bus, bus released, no completion (R8, R10)
    d0 = doneCnt;
    for (int v = 0; v < 256; v++) begin
      dpCycle(0, 1, 0, 0, 8'h00, DW'(v));
      check(mbrOut == DW'(v), "R4 c-load", mbrOut, v);
      if (v % 32 == 0) check(dataBus === {DW{1'bz}}, "R8 release", dataBus, 0);
    end
    check(doneCnt == d0, "R10 idle no done", doneCnt, d0);

    // R6: read every address through a two-cycle access
    for (int a = 0; a < 256; a++) begin
      d0 = doneCnt;
      dpCycle(1, 0, 1, 0, DW'(a), 8'h00);
      dpCycle(0, 0, 1, 0, 8'h00, 8'h00);
      check(mbrOut == tbMem[a], "R6 read", mbrOut, tbMem[a]);
      check(doneCnt == d0 + 1, "R6 done", doneCnt, d0 + 1);
    end
    idle();

    // R7: broken runs complete nothing; R4: C bus ignored while reading
    dpCycle(0, 1, 0, 0, 8'h00, 8'hC3);
    holdMbr = mbrOut;
    d0 = doneCnt;
    for (int k = 0; k < 4; k++) begin
      dpCycle(1, 1, 1, 0, DW'(k * 9), 8'h3C);
      idle();
      dpCycle(1, 0, 0, 1, DW'(k * 9), 8'h00);
      idle();
    end
    check(doneCnt == d0, "R7 no done", doneCnt, d0);
    check(mbrOut == holdMbr, "R7 mbr kept / R4 ignore", mbrOut, holdMbr);

    // R10: four back-to-back read cycles give two completions
    d0 = doneCnt;
    dpCycle(1, 0, 1, 0, 8'h20, 8'h00);
    for (int k = 0; k < 3; k++) dpCycle(0, 0, 1, 0, 8'h00, 8'h00);
    check(doneCnt == d0 + 2, "R10 back-to-back", doneCnt, d0 + 2);
    check(mbrOut == tbMem[32], "R10 data", mbrOut, tbMem[32]);
    idle();

    // R9, R8: writes then read back through the block
    for (int a = 0; a < 256; a += 7) begin
      logic [DW-1:0] dv;
      dv = DW'(a * 3 + 1);
      d0 = doneCnt;
      dpCycle(1, 1, 0, 1, DW'(a), dv);
      dpCycle(0, 0, 0, 1, 8'h00, 8'h00);
      check(dataBus == dv, "R8 drive", dataBus, dv);
      check(doneCnt == d0 + 1, "R9 done", doneCnt, d0 + 1);
      idle();
      check(dataBus === {DW{1'bz}}, "R8 release after write", dataBus, 0);
      dpCycle(0, 1, 0, 0, 8'h00, 8'h00);
      dpCycle(1, 0, 1, 0, DW'(a), 8'h00);
      dpCycle(0, 0, 1, 0, 8'h00, 8'h00);
      check(mbrOut == dv, "R9 readback", mbrOut, dv);
    end
    idle();

    // R2: reset in mid-operation
    dpCycle(1, 1, 0, 0, 8'hA5, 8'h5A);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(phaseStrobe == 4'b0001, "R2 mid phase", phaseStrobe, 1);
    check(addrOut == 0 && mbrOut == 0, "R2 mid regs", {addrOut, mbrOut}, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule